// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block sits beside a five-stage integer pipeline and makes its exceptions precise. Each stage can report a fault for the instruction it currently holds. The block does not act on a fault when it is raised. It records the fault in a small status vector that travels down the pipeline with that instruction. The fetch stage reports page, alignment or protection faults, decode reports an illegal opcode, and execute reports an arithmetic fault. The vector is examined at a single commit point in the memory stage, where the memory stage's own access fault is added.

When the instruction at the commit point carries any fault, the block takes a trap in that cycle. The instruction's memory write is blocked, and it never reaches write-back. The three younger instructions behind it are squashed. Fetch is redirected to a fixed trap vector, and on the next cycle the faulting PC and an encoded cause are visible. Instructions older than the faulting one have already passed the commit point, so they complete normally. A return-from-exception request redirects fetch back to the saved PC. A separate squash input lets the branch logic discard the instructions in fetch and decode, together with any faults they carry.

Top module: `preciseTrapCtl`

## Requirements
- R1: While reset is held and on the first cycle after it, trapTaken, memWrOk, retireValid and redirectValid are 0, and epcOut and causeOut are 0.
- R2: An instruction fetched in cycle n with no fault drives memWrOk in cycle n+3 and appears on retireValid/retirePc in cycle n+4.
- R3: An instruction with a fault takes the trap in cycle n+3. Fetch faults use code 1 page, 2 misaligned, 3 protection on ifFault, and these give cause 1, 2 and 3. An illegal opcode gives cause 4 and an arithmetic fault gives cause 5. Memory-stage fault codes 1, 2 and 3 on memFault give cause 6, 7 and 8. Cause 0 means no fault.
- R4: An instruction with several recorded faults reports the fault from its earliest stage (fetch, then decode, then execute, then memory).
- R5: Traps are taken in program order. An older instruction's later-stage fault is taken before a younger instruction's earlier-stage fault. The three instructions younger than a trapping one neither retire, write memory nor trap. Only one trap can be taken in any two consecutive cycles.
- R6: A trapping instruction has memWrOk at 0 in its commit cycle and does not retire.
- R7: In the trap cycle, redirectValid is 1 and redirectPc equals TRAP_VEC. From the next cycle, epcOut holds the faulting PC and causeOut holds its cause, and both stay unchanged until the next trap.
- R8: rfeReq in a cycle with no trap drives redirectValid with redirectPc equal to epcOut. A trap in the same cycle takes priority and redirects to TRAP_VEC.
- R9: squashYoung in cycle t discards the instructions fetched in cycles t and t-1 together with their faults. They never trap, retire or write memory.
- R10: Fault inputs raised for a fetch slot with ifValid at 0 are ignored. No trap follows, and memWrOk stays 0 for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ifValid | input | 1 | Fetch stage holds a real instruction |
| ifPc | input | PC_W | PC of the instruction in fetch |
| ifFault | input | 2 | Fetch access fault code (0 none, 1 page, 2 misaligned, 3 protection) |
| idUndef | input | 1 | Instruction in decode has an illegal opcode |
| exArith | input | 1 | Instruction in execute raised an arithmetic fault |
| memFault | input | 2 | Memory-stage access fault code, encoded as for ifFault |
| squashYoung | input | 1 | Discard the instructions in fetch and decode |
| rfeReq | input | 1 | Return from exception: resume at the saved PC |
| memWrOk | output | 1 | Memory-stage instruction may write memory |
| retireValid | output | 1 | An instruction reaches write-back and may write registers |
| retirePc | output | PC_W | PC of the retiring instruction |
| trapTaken | output | 1 | A trap is taken this cycle |
| redirectValid | output | 1 | Fetch must restart at redirectPc |
| redirectPc | output | PC_W | Fetch restart address |
| epcOut | output | PC_W | Saved PC of the last trapping instruction |
| causeOut | output | 4 | Cause code of the last trap |

## Verification
The properties assume that a stage's fault input belongs to whatever the pipeline holds in that stage in that cycle. They also assume the pipeline advances one stage every cycle. Because of this, the properties compare trap, retire and redirect against each other and against the saved state, and not against a fault's history. The stimulus keeps to these assumptions by driving each instruction's decode, execute and memory faults exactly one, two and three cycles after its fetch slot. It also drives faults for squashed and bubble slots, so those cases actually reach the block.

// File: rtl/trap_pkg.sv
package trap_pkg;

  // Stage registers ahead of the commit point: decode, execute, memory.
  localparam int STAGES = 3;

  typedef enum logic [3:0] {
    CAUSE_NONE        = 4'd0,
    CAUSE_FETCH_PAGE  = 4'd1,
    CAUSE_FETCH_ALIGN = 4'd2,
    CAUSE_FETCH_PROT  = 4'd3,
    CAUSE_ILLEGAL     = 4'd4,
    CAUSE_ARITH       = 4'd5,
    CAUSE_DATA_PAGE   = 4'd6,
    CAUSE_DATA_ALIGN  = 4'd7,
    CAUSE_DATA_PROT   = 4'd8
  } cause_e;

  // Status vector carried with each instruction.
  typedef struct packed {
    logic       valid;
    logic [1:0] fetchCode;
    logic       illegal;
    logic       arith;
  } statusVec_t;

  // Strobes from the commit control to the status path.
  typedef struct packed {
    logic [STAGES-1:0] killMask;
    logic              takeTrap;
    logic              retire;
    cause_e            cause;
  } ctlStrobe_t;

endpackage

// File: rtl/trapStatusPath.sv
module trapStatusPath
  import trap_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ifValid,
  input  logic [PC_W-1:0] ifPc,
  input  logic [1:0]      ifFault,
  input  logic            idUndef,
  input  logic            exArith,
  input  ctlStrobe_t      strobe,
  output statusVec_t      memVec,
  output logic            retireValid,
  output logic [PC_W-1:0] retirePc,
  output logic [PC_W-1:0] epcOut,
  output logic [3:0]      causeOut,
  output logic [PC_W-1:0] redirectPc
);

  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    statusVec_t      vecQ;
    statusVec_t      vecD;
    logic [PC_W-1:0] pcQ;
    logic [PC_W-1:0] pcD;

    if (i == 0) begin : gEntry
      always_comb begin
        vecD           = '0;
        vecD.valid     = ifValid;
        vecD.fetchCode = ifFault;
        pcD            = ifPc;
      end
    end else if (i == 1) begin : gDecode
      always_comb begin
        vecD         = gStage[i-1].vecQ;
        vecD.illegal = gStage[i-1].vecQ.illegal | idUndef;
        pcD          = gStage[i-1].pcQ;
      end
    end else begin : gExec
      always_comb begin
        vecD       = gStage[i-1].vecQ;
        vecD.arith = gStage[i-1].vecQ.arith | exArith;
        pcD        = gStage[i-1].pcQ;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vecQ <= '0;
        pcQ  <= '0;
      end else begin
        vecQ <= strobe.killMask[i] ? '0 : vecD;
        pcQ  <= pcD;
      end
    end
  end

  assign memVec = gStage[LAST].vecQ;

  logic [PC_W-1:0] epcQ;
  logic [3:0]      causeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retireValid <= 1'b0;
      retirePc    <= '0;
      epcQ        <= '0;
      causeQ      <= '0;
    end else begin
      retireValid <= strobe.retire;
      retirePc    <= gStage[LAST].pcQ;
      if (strobe.takeTrap) begin
        epcQ   <= gStage[LAST].pcQ;
        causeQ <= strobe.cause;
      end
    end
  end

  assign epcOut     = epcQ;
  assign causeOut   = causeQ;
  assign redirectPc = strobe.takeTrap ? TRAP_VEC : epcQ;

endmodule

// File: rtl/trapCommitCtl.sv
module trapCommitCtl
  import trap_pkg::*;
(
  input  statusVec_t memVec,
  input  logic [1:0] memFault,
  input  logic       squashYoung,
  input  logic       rfeReq,
  output ctlStrobe_t strobe,
  output logic       trapTaken,
  output logic       memWrOk,
  output logic       redirectValid
);

  cause_e cause;

  // Earliest stage wins inside one instruction.
  always_comb begin
    if (memVec.fetchCode != 2'd0)
      cause = cause_e'({2'b00, memVec.fetchCode});
    else if (memVec.illegal)
      cause = CAUSE_ILLEGAL;
    else if (memVec.arith)
      cause = CAUSE_ARITH;
    else if (memFault != 2'd0)
      cause = cause_e'(4'd5 + {2'b00, memFault});
    else
      cause = CAUSE_NONE;
  end

  assign trapTaken     = memVec.valid && (cause != CAUSE_NONE);
  assign memWrOk       = memVec.valid && (cause == CAUSE_NONE);
  assign redirectValid = trapTaken || rfeReq;

  always_comb begin
    strobe          = '0;
    strobe.takeTrap = trapTaken;
    strobe.retire   = memWrOk;
    strobe.cause    = cause;
    if (trapTaken)
      strobe.killMask = '1;
    else if (squashYoung)
      strobe.killMask = STAGES'(3);
  end

endmodule

// File: rtl/preciseTrapCtl.sv
module preciseTrapCtl
  import trap_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ifValid,
  input  logic [PC_W-1:0] ifPc,
  input  logic [1:0]      ifFault,
  input  logic            idUndef,
  input  logic            exArith,
  input  logic [1:0]      memFault,
  input  logic            squashYoung,
  input  logic            rfeReq,
  output logic            memWrOk,
  output logic            retireValid,
  output logic [PC_W-1:0] retirePc,
  output logic            trapTaken,
  output logic            redirectValid,
  output logic [PC_W-1:0] redirectPc,
  output logic [PC_W-1:0] epcOut,
  output logic [3:0]      causeOut
);

  statusVec_t memVec;
  ctlStrobe_t strobe;

  trapStatusPath #(.PC_W(PC_W), .TRAP_VEC(TRAP_VEC)) uPath (
    .clk(clk), .rstN(rstN),
    .ifValid(ifValid), .ifPc(ifPc), .ifFault(ifFault),
    .idUndef(idUndef), .exArith(exArith),
    .strobe(strobe), .memVec(memVec),
    .retireValid(retireValid), .retirePc(retirePc),
    .epcOut(epcOut), .causeOut(causeOut), .redirectPc(redirectPc)
  );

  trapCommitCtl uCtl (
    .memVec(memVec), .memFault(memFault),
    .squashYoung(squashYoung), .rfeReq(rfeReq),
    .strobe(strobe), .trapTaken(trapTaken),
    .memWrOk(memWrOk), .redirectValid(redirectValid)
  );

endmodule

// File: rtl/preciseTrapCheck.sv
module preciseTrapCheck #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0080
) (
  input logic            clk,
  input logic            rstN,
  input logic            rfeReq,
  input logic            memWrOk,
  input logic            retireValid,
  input logic            trapTaken,
  input logic            redirectValid,
  input logic [PC_W-1:0] redirectPc,
  input logic [PC_W-1:0] epcOut,
  input logic [3:0]      causeOut
);

  assert_clean_retires_R2: assert property (@(posedge clk) disable iff (!rstN)
    memWrOk |=> retireValid);

  assert_one_trap_R5: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> !trapTaken);

  assert_no_store_R6: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |-> !memWrOk);

  assert_no_retire_R6: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> !retireValid);

  assert_trap_vector_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |-> (redirectValid && redirectPc == TRAP_VEC));

  assert_cause_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> (causeOut != 4'd0));

  assert_epc_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !trapTaken |=> $stable(epcOut));

  assert_rfe_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rfeReq && !trapTaken) |-> (redirectValid && redirectPc == epcOut));

  assert_redirect_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (trapTaken || rfeReq));

endmodule

bind preciseTrapCtl preciseTrapCheck #(.PC_W(PC_W), .TRAP_VEC(TRAP_VEC)) uCheck (
  .clk(clk), .rstN(rstN), .rfeReq(rfeReq), .memWrOk(memWrOk),
  .retireValid(retireValid), .trapTaken(trapTaken),
  .redirectValid(redirectValid), .redirectPc(redirectPc),
  .epcOut(epcOut), .causeOut(causeOut)
);

// File: tb/tb_preciseTrapCtl.sv
`timescale 1ns/1ps
module tb_preciseTrapCtl;

  localparam int          PC_W = 32;
  localparam logic [31:0] TVEC = 32'h0000_0080;
  localparam int          NS   = 48;
  localparam int          NC   = 56;

  logic clk = 0;
  logic rstN = 0;
  logic ifValid = 0;
  logic [PC_W-1:0] ifPc = '0;
  logic [1:0] ifFault = '0;
  logic idUndef = 0, exArith = 0;
  logic [1:0] memFault = '0;
  logic squashYoung = 0, rfeReq = 0;
  logic memWrOk, retireValid, trapTaken, redirectValid;
  logic [PC_W-1:0] retirePc, redirectPc, epcOut;
  logic [3:0] causeOut;

  always #2 clk = ~clk;

  preciseTrapCtl #(.PC_W(PC_W), .TRAP_VEC(TVEC)) dut (
    .clk(clk), .rstN(rstN), .ifValid(ifValid), .ifPc(ifPc), .ifFault(ifFault),
    .idUndef(idUndef), .exArith(exArith), .memFault(memFault),
    .squashYoung(squashYoung), .rfeReq(rfeReq), .memWrOk(memWrOk),
    .retireValid(retireValid), .retirePc(retirePc), .trapTaken(trapTaken),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .epcOut(epcOut), .causeOut(causeOut)
  );

  // Stimulus tables: per fetch slot, and per cycle for squash and rfe.
  logic       v[NC];
  logic [1:0] fIf[NC];
  logic       fId[NC];
  logic       fEx[NC];
  logic [1:0] fMem[NC];
  logic       sq[NC];
  logic       rfe[NC];
  logic       killed[NC];

  logic        expTrap[NC];
  logic [31:0] expTrapPc[NC];
  logic [3:0]  expCause[NC];
  logic        expMemWr[NC];
  logic [31:0] expRedirPc[NC];

  logic [31:0] retireQ[$];
  logic [35:0] trapQ[$];

  int checks = 0, fails = 0;
  int curCyc = 0;
  bit running = 0, done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, curCyc, act, exp);
    end
  endtask

  function automatic logic [3:0] causeOf(input logic [1:0] a, input logic b,
                                         input logic c, input logic [1:0] d);
    if (a != 0) return {2'b00, a};
    if (b) return 4'd4;
    if (c) return 4'd5;
    if (d != 0) return 4'd5 + {2'b00, d};
    return 4'd0;
  endfunction

  function automatic logic [31:0] pcOf(input int s);
    return 32'h100 + 32'(s) * 4;
  endfunction

  task automatic buildExpect();
    logic [31:0] epcM;
    for (int t = 0; t < NC; t++) begin
      v[t] = (t < NS); fIf[t] = 0; fId[t] = 0; fEx[t] = 0; fMem[t] = 0;
      sq[t] = 0; rfe[t] = 0; killed[t] = 0;
      expTrap[t] = 0; expTrapPc[t] = 0; expCause[t] = 0; expMemWr[t] = 0;
      expRedirPc[t] = 0;
    end
    fIf[4] = 2; fId[5] = 1;                 // R3 fetch fault, squashed follower
    fId[8] = 1; fEx[10] = 1;                // R3 illegal opcode
    fId[13] = 1; fEx[13] = 1;               // R4 two faults, decode wins
    fMem[17] = 1; fIf[18] = 2;              // R5 older memory fault wins
    fMem[22] = 3;                           // R3 data protection
    v[26] = 0; fIf[26] = 1; fId[26] = 1;    // R10 bubble faults
    fIf[28] = 1; fEx[29] = 1; sq[29] = 1;   // R9 squash
    rfe[31] = 1;                            // R8 return
    fEx[34] = 1; rfe[37] = 1;               // R8 trap beats return
    fIf[40] = 1; fMem[40] = 2;              // R4 fetch beats memory
    fMem[44] = 2;                           // R3 data misaligned
    rfe[49] = 1;                            // R8 return to last epc

    for (int t = 0; t < NC; t++)
      if (sq[t]) begin
        killed[t] = 1;
        if (t > 0) killed[t-1] = 1;
      end
    for (int s = 0; s < NS; s++) begin
      if (v[s] && !killed[s]) begin
        logic [3:0] c;
        c = causeOf(fIf[s], fId[s], fEx[s], fMem[s]);
        if (c != 0) begin
          expTrap[s+3] = 1; expTrapPc[s+3] = pcOf(s); expCause[s+3] = c;
          trapQ.push_back({c, pcOf(s)});
          for (int k = 1; k <= 3; k++) killed[s+k] = 1;
        end else begin
          expMemWr[s+3] = 1;
          retireQ.push_back(pcOf(s));
        end
      end
    end
    epcM = 0;
    for (int t = 0; t < NC; t++) begin
      expRedirPc[t] = expTrap[t] ? TVEC : epcM;
      if (expTrap[t]) epcM = expTrapPc[t];
    end
  endtask

  // Driver
  initial begin
    buildExpect();
    repeat (3) @(posedge clk);
    #3;
    chk(!trapTaken && !memWrOk && !retireValid && !redirectValid, "R1", {trapTaken, memWrOk, retireValid, redirectValid}, 0);
    chk(epcOut == 0 && causeOut == 0, "R1", {epcOut, causeOut}, 0);
    for (int t = 0; t < NC; t++) begin
      @(posedge clk);
      #1;
      rstN = 1;
      curCyc = t;
      running = 1;
      ifValid = v[t];
      ifPc = pcOf(t);
      ifFault = fIf[t];
      idUndef = (t >= 1) ? fId[t-1] : 1'b0;
      exArith = (t >= 2) ? fEx[t-2] : 1'b0;
      memFault = (t >= 3) ? fMem[t-3] : 2'b0;
      squashYoung = sq[t];
      rfeReq = rfe[t];
    end
    @(posedge clk);
    #1;
    running = 0;
    ifValid = 0; idUndef = 0; exArith = 0; memFault = 0; squashYoung = 0; rfeReq = 0;
    repeat (2) @(posedge clk);
    chk(retireQ.size() == 0, "R2", retireQ.size(), 0);
    chk(trapQ.size() == 0, "R5", trapQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // Monitor / scoreboard
  logic        prevTrap = 0;
  logic [35:0] prevItem = '0;

  always @(posedge clk) begin
    #3;
    if (running) begin
      if (curCyc == 0)
        chk(epcOut == 0 && causeOut == 0 && !retireValid, "R1", {epcOut, causeOut}, 0);
      if (prevTrap) begin
        chk(epcOut == prevItem[31:0], "R7", epcOut, prevItem[31:0]);
        chk(causeOut == prevItem[35:32], "R3", causeOut, prevItem[35:32]);
      end
      prevTrap = 0;
      if (retireValid) begin
        if (retireQ.size() == 0) chk(0, "R5", retirePc, 0);
        else begin
          logic [31:0] e;
          e = retireQ.pop_front();
          chk(retirePc == e, "R2", retirePc, e);
        end
      end
      chk(trapTaken == expTrap[curCyc], "R5", trapTaken, expTrap[curCyc]);
      if (trapTaken) begin
        if (trapQ.size() == 0) chk(0, "R5", trapTaken, 0);
        else begin
          prevItem = trapQ.pop_front();
          prevTrap = 1;
        end
      end
      chk(memWrOk == expMemWr[curCyc], "R6", memWrOk, expMemWr[curCyc]);
      chk(redirectValid == (expTrap[curCyc] || rfe[curCyc]), "R8", redirectValid,
          expTrap[curCyc] || rfe[curCyc]);
      if (expTrap[curCyc] || rfe[curCyc])
        chk(redirectPc == expRedirPc[curCyc], "R7", redirectPc, expRedirPc[curCyc]);
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule